// File: doc/BRIEF.md
# Branch Resolution Unit

This unit resolves the control-transfer instructions of a 24-bit processor. Each cycle it takes the current instruction word, the current program counter and up to three register operand values. One cycle later it presents a taken flag and the address of the next instruction. The register operand values are read elsewhere; the unit only sees them as values.

The unit supports several kinds of transfer. Equality and ordered compares can be unsigned or signed. A sign test checks a single register against zero. There are unconditional jumps to a register plus an immediate, and to a register plus a second register. A fetch stage watches the taken flag so that it can throw away any word it fetched ahead on the fall-through path.

Top module: `bru_top`

## Requirements
- R1: An instruction whose bits 23..22 are not `11` is never taken, and its next pc is pc+1.
- R2: For a branch, bits 21..20 select the base test: `00` tests regAVal == regDVal, `01` tests unsigned regAVal < regDVal, and `10` tests signed regAVal < regDVal.
- R3: With bits 21..20 = `11` and bits 14..12 = `000`, the base test is "regAVal bit 23 is set" (negative).
- R4: With bits 21..19 = `110` and bits 14..12 = `100`, the branch is always taken and the target is regAVal plus the sign-extended immediate in bits 11..0.
- R5: With bits 21..19 = `111` and bits 14..12 = `100`, the branch is always taken and the target is regAVal + regBVal.
- R6: Bit 19 inverts the result of the base test for every conditional form. With bits 21..20 = `11` and any bits 14..12 other than `000` or `100`, the base test is false, so `110` is never taken and `111` is always taken.
- R7: Except for the forms in R4 and R5, a taken branch targets pc plus the sign-extended bits 11..0, modulo 2^24.
- R8: A branch that is not taken yields pc+1 modulo 2^24.
- R9: Outputs are registered. They show the result for the inputs sampled at the previous rising clock edge. While rstN is low, taken is 0 and nextPc is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instr | input | 24 | Instruction word |
| pc | input | 24 | Address of the instruction |
| regAVal | input | 24 | Value of the register in bits 18..15 |
| regDVal | input | 24 | Value of the register in bits 14..12 |
| regBVal | input | 24 | Value of the register in bits 11..9 |
| taken | output | 1 | Control transfer happens |
| nextPc | output | 24 | Next instruction address |

## Verification
Several properties are checked on every cycle:
- non-branch words never assert taken;
- every not-taken result equals the previous pc plus one;
- a register-indexed jump always lands on the sum of its two registers;
- an enabled sign test follows the sign bit of register A;
- the decoder never raises two compare or target strobes at once.

Other properties need the bench's scenarios:
- the exact relative and immediate-absolute targets;
- the inversion of each compare, and the signed versus unsigned choice on operands that disagree;
- wrapping at 2^24;
- the reserved combinations;
- the reset values.

// File: rtl/bru_pkg.sv
package bru_pkg;

  // Compare strobes from control to datapath; at most one set.
  typedef struct packed {
    logic cmpEq;
    logic cmpLtu;
    logic cmpLts;
    logic cmpNeg;
    logic cmpAlways;
  } cmpSel_t;

  // Target strobes; exactly one set.
  typedef struct packed {
    logic tgtRel;
    logic tgtAbsImm;
    logic tgtAbsReg;
  } tgtSel_t;

  typedef struct packed {
    logic    isBranch;
    logic    invert;
    cmpSel_t cmp;
    tgtSel_t tgt;
  } strobe_t;

endpackage

// File: rtl/bru_ctrl.sv
module bru_ctrl #(
  parameter int XLEN = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [XLEN-1:0]    instr,
  output bru_pkg::strobe_t   strb
);
  localparam int CLS_LSB  = XLEN - 2;
  localparam int COND_LSB = XLEN - 5;
  localparam int AF_LSB   = XLEN - 9;
  localparam int DF_LSB   = XLEN - 12;

  logic [1:0] cls;
  logic [2:0] cond;
  logic [2:0] dField;
  logic       unusedAField;

  assign cls          = instr[XLEN-1:CLS_LSB];
  assign cond         = instr[COND_LSB+2:COND_LSB];
  assign dField       = instr[DF_LSB+2:DF_LSB];
  assign unusedAField = ^instr[AF_LSB+3:AF_LSB] ^ ^instr[DF_LSB-1:0];

  logic specialPrefix;
  logic zeroForm;
  logic jumpForm;
  assign specialPrefix = (cond[2:1] == 2'b11);
  assign zeroForm      = specialPrefix && (dField == 3'b000);
  assign jumpForm      = specialPrefix && (dField == 3'b100);

  always_comb begin
    strb          = '0;
    strb.isBranch = (cls == 2'b11);
    strb.invert   = cond[0];
    strb.tgt.tgtRel = 1'b1;
    if (jumpForm) begin
      strb.invert        = 1'b0;
      strb.cmp.cmpAlways = 1'b1;
      strb.tgt.tgtRel    = 1'b0;
      if (cond[0]) strb.tgt.tgtAbsReg = 1'b1;
      else         strb.tgt.tgtAbsImm = 1'b1;
    end else if (zeroForm) begin
      strb.cmp.cmpNeg = 1'b1;
    end else begin
      unique case (cond[2:1])
        2'b00:   strb.cmp.cmpEq  = 1'b1;
        2'b01:   strb.cmp.cmpLtu = 1'b1;
        2'b10:   strb.cmp.cmpLts = 1'b1;
        default: ;  // reserved: base test false (R6)
      endcase
    end
  end

  // R6: strobe encoding toward the datapath stays consistent
  assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.cmp) && $onehot(strb.tgt));

  // R4: an unconditional jump never carries inversion
  assert_jump_noinv_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmp.cmpAlways |-> !strb.invert);

endmodule

// File: rtl/bru_dp.sv
module bru_dp #(
  parameter int XLEN = 24,
  parameter int IMMW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  bru_pkg::strobe_t   strb,
  input  logic [IMMW-1:0]    imm,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    regAVal,
  input  logic [XLEN-1:0]    regDVal,
  input  logic [XLEN-1:0]    regBVal,
  output logic               taken,
  output logic [XLEN-1:0]    nextPc
);
  localparam int EXTW = XLEN - IMMW;

  logic [XLEN-1:0] immExt;
  assign immExt = {{EXTW{imm[IMMW-1]}}, imm};

  logic baseHit;
  always_comb begin
    baseHit = 1'b0;
    if (strb.cmp.cmpEq)     baseHit = (regAVal == regDVal);
    if (strb.cmp.cmpLtu)    baseHit = (regAVal < regDVal);
    if (strb.cmp.cmpLts)    baseHit = ($signed(regAVal) < $signed(regDVal));
    if (strb.cmp.cmpNeg)    baseHit = regAVal[XLEN-1];
    if (strb.cmp.cmpAlways) baseHit = 1'b1;
  end

  logic takenD;
  assign takenD = strb.isBranch && (baseHit ^ strb.invert);

  logic [XLEN-1:0] relTgt, absImmTgt, absRegTgt, seqPc, tgt;
  assign relTgt    = pc + immExt;
  assign absImmTgt = regAVal + immExt;
  assign absRegTgt = regAVal + regBVal;
  assign seqPc     = pc + {{(XLEN-1){1'b0}}, 1'b1};

  always_comb begin
    tgt = relTgt;
    if (strb.tgt.tgtAbsImm) tgt = absImmTgt;
    if (strb.tgt.tgtAbsReg) tgt = absRegTgt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      taken  <= 1'b0;
      nextPc <= '0;
    end else begin
      taken  <= takenD;
      nextPc <= takenD ? tgt : seqPc;
    end
  end

  // R8: fall-through address follows the previous pc
  assert_fallthrough_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !taken) |-> (nextPc == $past(pc) + 1'b1));

  // R1: non-branch words never transfer control
  assert_nonbranch_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strb.isBranch)) |-> !taken);

  // R5: register-indexed jump lands on the register sum
  assert_regjump_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.isBranch && strb.tgt.tgtAbsReg))
      |-> (taken && nextPc == $past(regAVal) + $past(regBVal)));

  // R3: the non-inverted sign test follows the sign of register A
  assert_signtest_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.isBranch && strb.cmp.cmpNeg && !strb.invert))
      |-> (taken == $past(regAVal[XLEN-1])));

endmodule

// File: rtl/bru_top.sv
module bru_top #(
  parameter int XLEN = 24,
  parameter int IMMW = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] regAVal,
  input  logic [XLEN-1:0] regDVal,
  input  logic [XLEN-1:0] regBVal,
  output logic            taken,
  output logic [XLEN-1:0] nextPc
);
  bru_pkg::strobe_t strb;

  bru_ctrl #(.XLEN(XLEN)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .instr (instr),
    .strb  (strb)
  );

  bru_dp #(.XLEN(XLEN), .IMMW(IMMW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .imm     (instr[IMMW-1:0]),
    .pc      (pc),
    .regAVal (regAVal),
    .regDVal (regDVal),
    .regBVal (regBVal),
    .taken   (taken),
    .nextPc  (nextPc)
  );
endmodule

// File: tb/sim_bru_top.sv
`timescale 1ns/1ps
module sim_bru_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] instr = '0, pc = '0, regAVal = '0, regDVal = '0, regBVal = '0;
  logic        taken;
  logic [23:0] nextPc;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  bru_top u0 (
    .clk(clk), .rstN(rstN), .instr(instr), .pc(pc),
    .regAVal(regAVal), .regDVal(regDVal), .regBVal(regBVal),
    .taken(taken), .nextPc(nextPc)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  cls;
    logic [2:0]  cond;
    logic [2:0]  dFld;
    logic [11:0] imm;
    logic [23:0] vPc;
    logic [23:0] vA;
    logic [23:0] vD;
    logic [23:0] vB;
    logic        expT;
    logic [23:0] expPc;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 2'b11, 3'b000, 3'd3, 12'h010, 24'h000100, 24'h5, 24'h5, 24'h0, 1'b1, 24'h000110}, // R2 eq hit
    '{4'd8, 2'b11, 3'b000, 3'd3, 12'h010, 24'h000100, 24'h5, 24'h6, 24'h0, 1'b0, 24'h000101}, // R8 eq miss
    '{4'd6, 2'b11, 3'b001, 3'd3, 12'h010, 24'h000100, 24'h5, 24'h6, 24'h0, 1'b1, 24'h000110}, // R6 inverted eq
    '{4'd7, 2'b11, 3'b010, 3'd3, 12'hFFE, 24'h000100, 24'h1, 24'hFFFFFF, 24'h0, 1'b1, 24'h0000FE}, // R7 ltu, negative offset
    '{4'd2, 2'b11, 3'b100, 3'd3, 12'h020, 24'h000100, 24'h1, 24'hFFFFFF, 24'h0, 1'b0, 24'h000101}, // R2 signed lt false
    '{4'd6, 2'b11, 3'b101, 3'd3, 12'h020, 24'h000100, 24'h1, 24'hFFFFFF, 24'h0, 1'b1, 24'h000120}, // R6 signed ge
    '{4'd6, 2'b11, 3'b011, 3'd3, 12'h020, 24'h000100, 24'h1, 24'hFFFFFF, 24'h0, 1'b0, 24'h000101}, // R6 unsigned ge
    '{4'd2, 2'b11, 3'b100, 3'd3, 12'h020, 24'h000100, 24'hFFFFFF, 24'h1, 24'h0, 1'b1, 24'h000120}, // R2 signed lt true
    '{4'd3, 2'b11, 3'b110, 3'd0, 12'h004, 24'h000200, 24'h800000, 24'h0, 24'h0, 1'b1, 24'h000204}, // R3 negative
    '{4'd3, 2'b11, 3'b111, 3'd0, 12'h004, 24'h000200, 24'h800000, 24'h0, 24'h0, 1'b0, 24'h000201}, // R3 inverted
    '{4'd3, 2'b11, 3'b111, 3'd0, 12'h004, 24'h000200, 24'h000000, 24'h0, 24'h0, 1'b1, 24'h000204}, // R3 zero is non-negative
    '{4'd4, 2'b11, 3'b110, 3'd4, 12'hFFF, 24'h000050, 24'h000300, 24'h0, 24'h0, 1'b1, 24'h0002FF}, // R4 abs imm
    '{4'd5, 2'b11, 3'b111, 3'd4, 12'h000, 24'h000050, 24'hFFFFF0, 24'h0, 24'h20, 1'b1, 24'h000010}, // R5 reg sum wrap
    '{4'd7, 2'b11, 3'b000, 3'd3, 12'h001, 24'hFFFFFF, 24'h7, 24'h7, 24'h0, 1'b1, 24'h000000}, // R7 wrap
    '{4'd8, 2'b11, 3'b000, 3'd3, 12'h001, 24'hFFFFFF, 24'h7, 24'h8, 24'h0, 1'b0, 24'h000000}, // R8 wrap
    '{4'd6, 2'b11, 3'b110, 3'd2, 12'h010, 24'h000100, 24'hFFFFFF, 24'h0, 24'h0, 1'b0, 24'h000101}, // R6 reserved never
    '{4'd6, 2'b11, 3'b111, 3'd3, 12'h010, 24'h000100, 24'h0, 24'h0, 24'h0, 1'b1, 24'h000110}, // R6 reserved always
    '{4'd1, 2'b01, 3'b000, 3'd3, 12'h010, 24'h000100, 24'h5, 24'h5, 24'h0, 1'b0, 24'h000101}  // R1 not a branch
  };

  task automatic check(input string tag, input logic gotT, input logic [23:0] gotPc,
                       input logic expT, input logic [23:0] expPc);
    testCount++;
    if (gotT !== expT || gotPc !== expPc) begin
      failCount++;
      $display("FAIL %s: taken=%0b nextPc=%06h expected taken=%0b nextPc=%06h",
               tag, gotT, gotPc, expT, expPc);
    end
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 reset", taken, nextPc, 1'b0, 24'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr   = {VECS[i].cls, VECS[i].cond, 4'h0, VECS[i].dFld, VECS[i].imm};
      pc      = VECS[i].vPc;
      regAVal = VECS[i].vA;
      regDVal = VECS[i].vD;
      regBVal = VECS[i].vB;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), taken, nextPc,
            VECS[i].expT, VECS[i].expPc);
    end

    // R9: output lags input by exactly one edge
    @(negedge clk);
    instr = {2'b11, 3'b110, 4'h0, 3'd4, 12'h010}; regAVal = 24'h001000; pc = 24'h0;
    @(posedge clk); #1;
    check("R9 latency", taken, nextPc, 1'b1, 24'h001010);
    @(negedge clk);
    instr = 24'h0; pc = 24'h000040;
    check("R9 hold until edge", taken, nextPc, 1'b1, 24'h001010);
    @(negedge clk);
    check("R1 zero word", taken, nextPc, 1'b0, 24'h000041);

    // R9: reset while a taken result is held
    instr = {2'b11, 3'b110, 4'h0, 3'd4, 12'h001}; regAVal = 24'h000500;
    @(negedge clk);
    check("R4 before reset", taken, nextPc, 1'b1, 24'h000501);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 reset clears", taken, nextPc, 1'b0, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R4 after reset", taken, nextPc, 1'b1, 24'h000501);

    finish();
  end
endmodule